// File: doc/BRIEF.md
# Shared-Cache Utility Monitor and Way Partitioner

Two cores share one 16-way cache. This block decides how many of the ways each core may hold. For each core it keeps one hit counter per recency position. The events come from a sampled shadow directory kept outside the block: a hit at position 0 is a hit on the most recently used line, and a hit at position 15 is a hit on the least recently used line. Summing a core's counters from position 0 up to position k-1 gives the number of hits that core would have had with k ways.

Once per fixed interval of cycles, a sequential search tries every split. It tests one candidate per cycle and gives core 0 between 1 and 15 ways. It keeps the split with the largest combined hit count, publishes it, and then halves every counter so that older behaviour fades out of the history.

The block also applies the published split to replacement. On each miss it is given the requesting core, the owner bit of every line in the set and each line's recency rank. It returns the way to evict one cycle later.

Top module: `util_way_partitioner`

## Requirements
- R1: While reset is high and on the first cycle after it, `alloc0` is 8, `split_done` is 0 and `victim_vld` is 0.
- R2: A hit event with `hitN_vld` = 1 and position p (0 = most recent, 15 = least recent) adds one to counter p of core N. Counters saturate at their maximum.
- R3: At each repartition, `alloc0` is set to the value a in 1..15 that maximises the sum of core 0's counters 0..a-1 plus core 1's counters 0..15-a. Core 1 holds 16 - `alloc0` ways.
- R4: When several values of a give the same largest sum, the smallest of them is chosen.
- R5: `split_done` is a one-cycle pulse that recurs every INTERVAL cycles. `alloc0` changes only in the cycle in which `split_done` is 1.
- R6: In the cycle that `alloc0` is updated, every counter of both cores is replaced by half of its value, rounded down. A hit that arrives in that same cycle is added before the halving.
- R7: On a miss, count the lines in the set whose owner bit equals `miss_core` (owner bit 0 = core 0, 1 = core 1). If that count is below the core's allotment (`alloc0` for core 0, 16 - `alloc0` for core 1), the victim is the line of the other core with the largest rank.
- R8: If the count in R7 is equal to or above the allotment, the victim is the requesting core's own line with the largest rank. Way w's rank sits in `miss_rank[4w+3:4w]`, where 0 is the most recent line and 15 the least recent.
- R9: `victim_vld` and `victim_way` appear on the clock edge after a cycle with `miss_vld` = 1. `victim_vld` is 0 after any cycle without a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hit0_vld | input | 1 | Sampled hit event for core 0 |
| hit0_pos | input | 4 | Recency position of the core 0 hit |
| hit1_vld | input | 1 | Sampled hit event for core 1 |
| hit1_pos | input | 4 | Recency position of the core 1 hit |
| miss_vld | input | 1 | Victim request |
| miss_core | input | 1 | Core that missed |
| miss_owner | input | 16 | Owner core bit of each way in the set |
| miss_rank | input | 64 | 4-bit recency rank of each way |
| alloc0 | output | 5 | Ways currently allotted to core 0 |
| split_done | output | 1 | Pulse when a new split is published |
| victim_vld | output | 1 | Victim result valid |
| victim_way | output | 4 | Way chosen for eviction |

## Verification
The hardest results to reach are the splits at the two ends of the range and a split that exists only because of aging. Each of these needs a hit history that builds up across more than one interval. The stimulus therefore feeds planned hit counts in the gap between repartitions.

In the first interval, the histories make core 0 peak at 5 ways. The second interval adds hits deep in core 0's stack. After halving, those hits make 15 ways the winner; without halving, the result would have been a tie that resolves to 5. A later burst deep in core 1's stack forces the split back down to 1.

Victim requests are issued both with the default split and with the 15/1 split. This places the owned count exactly on each core's allotment and one line below it.

// File: rtl/uwp_pkg.sv
package uwp_pkg;

    localparam int WAYS    = 16;
    localparam int POS_W   = $clog2(WAYS);
    localparam int ALLOC_W = $clog2(WAYS + 1);

    typedef logic [POS_W-1:0]   pos_t;
    typedef logic [ALLOC_W-1:0] alloc_t;

    typedef struct packed {
        logic                   valid;
        logic                   core;
        logic [WAYS-1:0]        owner;
        logic [WAYS*POS_W-1:0]  rank;
    } miss_req_t;

    typedef struct packed {
        logic valid;
        pos_t way;
    } victim_t;

    // Ways granted to a core given core 0's share.
    function automatic alloc_t share_of(input logic core, input alloc_t a0);
        return core ? (alloc_t'(WAYS) - a0) : a0;
    endfunction

endpackage

// File: rtl/uwp_hit_bank.sv
module uwp_hit_bank
    import uwp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  hit_vld,
    input  pos_t                  hit_pos,
    input  logic                  halve,
    output logic [WAYS*CNT_W-1:0] cnt_flat
);

    logic [CNT_W-1:0] cnt_q [WAYS];

    for (genvar g = 0; g < WAYS; g++) begin : g_pos
        logic             bump;
        logic [CNT_W-1:0] nxt;

        assign bump = hit_vld && (hit_pos == pos_t'(g)) && (cnt_q[g] != {CNT_W{1'b1}});
        assign nxt  = cnt_q[g] + CNT_W'(bump);

        always_ff @(posedge clk) begin
            if (rst)        cnt_q[g] <= '0;
            else if (halve) cnt_q[g] <= nxt >> 1;
            else            cnt_q[g] <= nxt;
        end

        assign cnt_flat[g*CNT_W +: CNT_W] = cnt_q[g];

        // R2: between repartitions a counter never loses hits
        assert_cnt_mono_R2: assert property (@(posedge clk) disable iff (rst)
            !halve |=> cnt_q[g] >= $past(cnt_q[g]));

        // R6: aging never grows a counter
        assert_halve_shrinks_R6: assert property (@(posedge clk) disable iff (rst)
            halve |=> cnt_q[g] <= $past(cnt_q[g]));
    end

endmodule

// File: rtl/uwp_split_search.sv
module uwp_split_search
    import uwp_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int INTERVAL = 5_000_000
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [WAYS*CNT_W-1:0] cnt0_flat,
    input  logic [WAYS*CNT_W-1:0] cnt1_flat,
    output alloc_t                alloc_q,
    output logic                  done_q,
    output logic                  halve
);

    localparam int IC_W  = $clog2(INTERVAL + 1);
    localparam int SUM_W = CNT_W + POS_W + 1;

    logic [IC_W-1:0]  ic_q;
    logic             busy_q;
    alloc_t           cand_q;
    logic [SUM_W-1:0] best_q;
    alloc_t           best_a_q;

    logic [SUM_W-1:0] sum0, sum1, total, pick_total;
    alloc_t           pick_a;
    logic             better, start, last;

    // Hits each core would get for the candidate split
    always_comb begin
        sum0 = '0;
        sum1 = '0;
        for (int i = 0; i < WAYS; i++) begin
            if (i < int'(cand_q))
                sum0 = sum0 + SUM_W'(cnt0_flat[i*CNT_W +: CNT_W]);
            if (i < WAYS - int'(cand_q))
                sum1 = sum1 + SUM_W'(cnt1_flat[i*CNT_W +: CNT_W]);
        end
        total = sum0 + sum1;
    end

    // Strictly greater keeps the smaller candidate on ties
    assign better     = (cand_q == alloc_t'(1)) || (total > best_q);
    assign pick_a     = better ? cand_q : best_a_q;
    assign pick_total = better ? total  : best_q;
    assign start      = (ic_q == IC_W'(INTERVAL - 1)) && !busy_q;
    assign last       = busy_q && (cand_q == alloc_t'(WAYS - 1));
    assign halve      = last;

    always_ff @(posedge clk) begin
        if (rst) begin
            ic_q     <= '0;
            busy_q   <= 1'b0;
            cand_q   <= alloc_t'(1);
            best_q   <= '0;
            best_a_q <= alloc_t'(1);
            alloc_q  <= alloc_t'(WAYS / 2);
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (ic_q == IC_W'(INTERVAL - 1)) ic_q <= '0;
            else                             ic_q <= ic_q + IC_W'(1);

            if (start) begin
                busy_q <= 1'b1;
                cand_q <= alloc_t'(1);
            end else if (busy_q) begin
                best_q   <= pick_total;
                best_a_q <= pick_a;
                if (last) begin
                    busy_q  <= 1'b0;
                    alloc_q <= pick_a;
                    done_q  <= 1'b1;
                end else begin
                    cand_q <= cand_q + alloc_t'(1);
                end
            end
        end
    end

    // R3: every core keeps at least one way
    assert_alloc_range_R3: assert property (@(posedge clk) disable iff (rst)
        (alloc_q >= alloc_t'(1)) && (alloc_q <= alloc_t'(WAYS - 1)));

    // R5: publication is a single-cycle pulse
    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    // R5: split only moves together with the pulse
    assert_alloc_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !done_q |-> $stable(alloc_q));

endmodule

// File: rtl/uwp_victim_select.sv
module uwp_victim_select
    import uwp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  miss_req_t req,
    input  alloc_t    alloc0,
    output victim_t   vic_q
);

    alloc_t owned, limit;
    logic   tgt, found;
    pos_t   tgt_rank, tgt_way, any_rank, any_way, sel_way;

    always_comb begin
        owned = '0;
        for (int w = 0; w < WAYS; w++)
            if (req.owner[w] == req.core) owned = owned + alloc_t'(1);
        limit = share_of(req.core, alloc0);
        tgt   = (owned < limit) ? ~req.core : req.core;

        found    = 1'b0;
        tgt_rank = '0;
        tgt_way  = '0;
        any_rank = '0;
        any_way  = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (req.owner[w] == tgt &&
                (!found || req.rank[w*POS_W +: POS_W] > tgt_rank)) begin
                found    = 1'b1;
                tgt_rank = req.rank[w*POS_W +: POS_W];
                tgt_way  = pos_t'(w);
            end
            if (w == 0 || req.rank[w*POS_W +: POS_W] > any_rank) begin
                any_rank = req.rank[w*POS_W +: POS_W];
                any_way  = pos_t'(w);
            end
        end
        sel_way = found ? tgt_way : any_way;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vic_q <= '0;
        end else begin
            vic_q.valid <= req.valid;
            if (req.valid) vic_q.way <= sel_way;
        end
    end

    // R9: a result follows each request by exactly one cycle
    assert_victim_follow_R9: assert property (@(posedge clk) disable iff (rst)
        req.valid |=> vic_q.valid);

    assert_victim_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !req.valid |=> !vic_q.valid);

endmodule

// File: rtl/util_way_partitioner.sv
module util_way_partitioner
    import uwp_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int INTERVAL = 5_000_000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        hit0_vld,
    input  logic [3:0]  hit0_pos,
    input  logic        hit1_vld,
    input  logic [3:0]  hit1_pos,
    input  logic        miss_vld,
    input  logic        miss_core,
    input  logic [15:0] miss_owner,
    input  logic [63:0] miss_rank,
    output logic [4:0]  alloc0,
    output logic        split_done,
    output logic        victim_vld,
    output logic [3:0]  victim_way
);

    logic [WAYS*CNT_W-1:0] cnt0_flat, cnt1_flat;
    logic                  halve;
    alloc_t                alloc_q;
    miss_req_t             req;
    victim_t               vic;

    uwp_hit_bank #(.CNT_W(CNT_W)) bank0_i (
        .clk(clk), .rst(rst), .hit_vld(hit0_vld), .hit_pos(hit0_pos),
        .halve(halve), .cnt_flat(cnt0_flat));

    uwp_hit_bank #(.CNT_W(CNT_W)) bank1_i (
        .clk(clk), .rst(rst), .hit_vld(hit1_vld), .hit_pos(hit1_pos),
        .halve(halve), .cnt_flat(cnt1_flat));

    uwp_split_search #(.CNT_W(CNT_W), .INTERVAL(INTERVAL)) search_i (
        .clk(clk), .rst(rst), .cnt0_flat(cnt0_flat), .cnt1_flat(cnt1_flat),
        .alloc_q(alloc_q), .done_q(split_done), .halve(halve));

    assign req.valid = miss_vld;
    assign req.core  = miss_core;
    assign req.owner = miss_owner;
    assign req.rank  = miss_rank;

    uwp_victim_select victim_i (
        .clk(clk), .rst(rst), .req(req), .alloc0(alloc_q), .vic_q(vic));

    assign alloc0     = alloc_q;
    assign victim_vld = vic.valid;
    assign victim_way = vic.way;

endmodule

// File: tb/util_way_partitioner_tb.sv
module util_way_partitioner_tb_top;

    localparam int INTERVAL = 200;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hit0_vld = 1'b0, hit1_vld = 1'b0;
    logic [3:0]  hit0_pos = '0, hit1_pos = '0;
    logic        miss_vld = 1'b0, miss_core = 1'b0;
    logic [15:0] miss_owner = '0;
    logic [63:0] miss_rank = '0;
    logic [4:0]  alloc0;
    logic        split_done, victim_vld;
    logic [3:0]  victim_way;

    int n_chk = 0, n_bad = 0, cyc = 0, t_prev = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc++;

    util_way_partitioner #(.CNT_W(16), .INTERVAL(INTERVAL)) dut_i (
        .clk(clk), .rst(rst), .hit0_vld(hit0_vld), .hit0_pos(hit0_pos),
        .hit1_vld(hit1_vld), .hit1_pos(hit1_pos), .miss_vld(miss_vld),
        .miss_core(miss_core), .miss_owner(miss_owner), .miss_rank(miss_rank),
        .alloc0(alloc0), .split_done(split_done), .victim_vld(victim_vld),
        .victim_way(victim_way));

    // {core, owner[15:0], reversed_rank, expected_way}; split is 8/8
    localparam logic [21:0] VEC [9] = '{
        {1'b0, 16'hFFFF, 1'b0, 4'd15},  // R7 core0 owns none -> other LRU
        {1'b0, 16'hFF00, 1'b0, 4'd7 },  // R8 owns 8 = share
        {1'b1, 16'hFF00, 1'b0, 4'd15},  // R8
        {1'b1, 16'h0000, 1'b0, 4'd15},  // R7
        {1'b1, 16'hFFFF, 1'b1, 4'd0 },  // R8 reversed ranks
        {1'b0, 16'hFFFF, 1'b1, 4'd0 },  // R7 reversed ranks
        {1'b0, 16'h3FFF, 1'b0, 4'd13},  // R7 other's oldest is way 13
        {1'b1, 16'h01FF, 1'b0, 4'd8 },  // R8 owns 9 > 8
        {1'b0, 16'h0F00, 1'b1, 4'd0 }   // R8 owns 12
    };

    function automatic logic [63:0] mk_rank(input logic rev);
        logic [63:0] r;
        for (int w = 0; w < 16; w++) r[w*4 +: 4] = rev ? 4'(15 - w) : 4'(w);
        return r;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_miss(input logic core, input logic [15:0] own,
                           input logic rev, input int exp, input string req);
        @(negedge clk);
        miss_vld = 1'b1; miss_core = core; miss_owner = own; miss_rank = mk_rank(rev);
        @(negedge clk);
        miss_vld = 1'b0;
        check({req, " R9 valid"}, int'(victim_vld), 1);
        check(req, int'(victim_way), exp);
        @(negedge clk);
        check("R9 idle", int'(victim_vld), 0);
    endtask

    task automatic feed(input logic core, input int pos, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (core) begin hit1_vld = 1'b1; hit1_pos = 4'(pos); end
            else      begin hit0_vld = 1'b1; hit0_pos = 4'(pos); end
        end
        @(negedge clk);
        hit0_vld = 1'b0; hit1_vld = 1'b0;
    endtask

    task automatic wait_done(output int t);
        do @(negedge clk); while (!split_done);
        t = cyc;
    endtask

    initial begin
        #(5.0 * 20000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int t;
        repeat (3) @(negedge clk);
        check("R1 alloc", int'(alloc0), 8);
        check("R1 done", int'(split_done), 0);
        check("R1 victim", int'(victim_vld), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 alloc after release", int'(alloc0), 8);

        foreach (VEC[i])
            do_miss(VEC[i][21], VEC[i][20:5], VEC[i][4], int'(VEC[i][3:0]),
                    VEC[i][3:0] == 4'd15 && VEC[i][21] == 1'b0 ? "R7" : "R7/R8");

        // All counters zero: every split ties, smallest wins
        wait_done(t);
        t_prev = t;
        check("R4 tie -> 1", int'(alloc0), 1);
        @(negedge clk);
        check("R5 pulse width", int'(split_done), 0);

        // core0 H0..4 = 10, core1 H0..2 = 20 -> best a = 5 (110)
        for (int p = 0; p < 5; p++) feed(1'b0, p, 10);
        for (int p = 0; p < 3; p++) feed(1'b1, p, 20);
        wait_done(t);
        check("R5 period", t - t_prev, INTERVAL);
        t_prev = t;
        check("R2/R3 split", int'(alloc0), 5);

        // With halving, core0 deep hits make a = 15 the winner
        feed(1'b0, 14, 40);
        wait_done(t);
        check("R5 period", t - t_prev, INTERVAL);
        check("R6 aged split", int'(alloc0), 15);

        do_miss(1'b1, 16'h0001, 1'b0, 0,  "R8 share 1");
        do_miss(1'b0, 16'h0001, 1'b0, 15, "R8 share 15");
        do_miss(1'b0, 16'h0003, 1'b0, 1,  "R7 share 15");

        // Deep core1 hits pull the split to the low end
        feed(1'b1, 14, 60);
        wait_done(t);
        check("R3 low end", int'(alloc0), 1);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule